// File: doc/BRIEF.md
# Streaming Sector Hamming Code Generator

This block builds a three-byte single-error-correcting Hamming code for a 512-byte flash data sector. It computes the code while the sector's bytes stream through, one byte per clock at most. The code is ready one cycle after the last byte, so the data does not have to be buffered. A storage controller places the block on its write path, where the code goes to the spare area, and on its read path, where the code is compared with the stored copy.

Each accepted byte is reduced to its parity.

- For every byte with odd parity, the byte's position in the sector is folded into a true row register.
- The complement of that position is folded into a prime row register.
- A global accumulator XORs all bytes together, and the column parities come from it.

At the end of the sector the row and column terms are packed into a fixed, interleaved layout and every bit is inverted. An erased sector (all ones) therefore gives an erased code.

The first byte of a sector is marked with a start flag. Bytes are counted internally, and a sector closes by itself after its 512th accepted byte. A new sector may begin on the very next clock.

Top module: `nand_hamming_gen`

## Requirements
- R1: After reset, `ecc_done` is low and all three code bytes read 0xFF.
- R2: A byte is taken only in a cycle with `in_valid` high. Cycles with `in_valid` low change neither the byte count nor any parity state, whatever `in_data` and `in_sos` hold.
- R3: A valid byte with `in_sos` high is byte index 0 of a new sector. Any partial sector before it is discarded.
- R4: The true row term for position k (k = 0..8) is the XOR of the data bits in all bytes whose index has bit k set.
- R5: The prime row term for position k is the XOR of the data bits in all bytes whose index has bit k clear.
- R6: Column terms are parities of the XOR of all bytes under masks: C4=0xF0, C4'=0x0F, C2=0xCC, C2'=0x33, C1=0xAA, C1'=0x55. `ecc_hi` bits 7..0 are C4, C4', C2, C2', C1, C1', then true and prime row term 8.
- R7: `ecc_mid` bits 7..0 hold the true and prime row terms 7, 6, 5 and 4, interleaved with true first in each pair.
- R8: `ecc_lo` bits 7..0 hold the true and prime row terms 3, 2, 1 and 0, interleaved the same way.
- R9: All code bits are output inverted, so an all-0xFF sector and an all-0x00 sector both give 0xFF in all three bytes.
- R10: `ecc_done` is high for exactly the one cycle after the 512th accepted byte. The code bytes change only in that cycle and hold their value until the next such cycle.
- R11: A sector may follow the previous one with no idle cycle, with or without `in_sos` on its first byte, and the two codes are independent.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A data byte is present this cycle |
| in_sos | input | 1 | Present byte is the first of a sector |
| in_data | input | 8 | Data byte |
| ecc_done | output | 1 | One-cycle pulse: code bytes just updated |
| ecc_lo | output | 8 | Code byte 0 (row terms 3..0) |
| ecc_mid | output | 8 | Code byte 1 (row terms 7..4) |
| ecc_hi | output | 8 | Code byte 2 (column terms, row term 8) |

## Verification
The bench injects single set bits at the first byte, the last byte and bytes with alternating index patterns. A swapped true/prime term, a mis-ordered interleave or a wrong column mask then shows up as a wrong bit in the matching code byte. Sectors with random gaps in `in_valid` and junk on idle cycles catch a design that counts or folds bytes it should ignore. A restart in the middle of a sector catches a design that keeps stale parity. Back-to-back sectors with no idle cycle catch an off-by-one in the end-of-sector clear, which would leak the last byte into the next code or delay `ecc_done` by one cycle.

// File: rtl/nand_hamming_gen.sv
module nand_hamming_gen #(
  parameter int SECTOR_BYTES = 512
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       in_valid,
  input  logic       in_sos,
  input  logic [7:0] in_data,
  output logic       ecc_done,
  output logic [7:0] ecc_lo,
  output logic [7:0] ecc_mid,
  output logic [7:0] ecc_hi
);
  localparam int IDX_W = $clog2(SECTOR_BYTES);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(SECTOR_BYTES - 1);

  logic [IDX_W-1:0] cnt, idx, row_t, row_p, nxt_t, nxt_p;
  logic [7:0] gacc, nxt_g;
  logic [7:0] pk_lo, pk_mid, pk_hi;
  logic odd, last;

  assign idx   = in_sos ? '0 : cnt;
  assign odd   = ^in_data;
  assign last  = (idx == LAST_IDX);
  assign nxt_t = (in_sos ? '0 : row_t) ^ (odd ? idx : '0);
  assign nxt_p = (in_sos ? '0 : row_p) ^ (odd ? ~idx : '0);
  assign nxt_g = (in_sos ? '0 : gacc) ^ in_data;

  always_comb begin
    pk_hi = {^(nxt_g & 8'hF0), ^(nxt_g & 8'h0F), ^(nxt_g & 8'hCC), ^(nxt_g & 8'h33),
             ^(nxt_g & 8'hAA), ^(nxt_g & 8'h55), nxt_t[8], nxt_p[8]};
    for (int i = 0; i < 4; i++) begin
      pk_mid[2*i+1] = nxt_t[4+i];
      pk_mid[2*i]   = nxt_p[4+i];
      pk_lo[2*i+1]  = nxt_t[i];
      pk_lo[2*i]    = nxt_p[i];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt      <= '0;
      row_t    <= '0;
      row_p    <= '0;
      gacc     <= '0;
      ecc_done <= 1'b0;
      ecc_lo   <= 8'hFF;
      ecc_mid  <= 8'hFF;
      ecc_hi   <= 8'hFF;
    end else begin
      ecc_done <= 1'b0;
      if (in_valid) begin
        if (last) begin
          cnt      <= '0;
          row_t    <= '0;
          row_p    <= '0;
          gacc     <= '0;
          ecc_done <= 1'b1;
          ecc_lo   <= ~pk_lo;
          ecc_mid  <= ~pk_mid;
          ecc_hi   <= ~pk_hi;
        end else begin
          cnt   <= idx + 1'b1;
          row_t <= nxt_t;
          row_p <= nxt_p;
          gacc  <= nxt_g;
        end
      end
    end
  end

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(cnt) && $stable(gacc) && $stable(row_t) && $stable(row_p)); // R2
  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && !in_sos && cnt != LAST_IDX |=> cnt == $past(cnt) + 1'b1); // R2
  AST_SOS_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_sos |=> cnt == IDX_W'(1)); // R3
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    ecc_done |=> !ecc_done); // R10
  AST_DONE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    ecc_done |-> $past(in_valid) && cnt == '0); // R10
  AST_CODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !ecc_done |-> $stable({ecc_hi, ecc_mid, ecc_lo})); // R10
endmodule

// File: tb/test_nand_hamming_gen.sv
`timescale 1ns/1ps
module test_nand_hamming_gen;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, in_sos = 1'b0;
  logic [7:0] in_data = 8'h00;
  logic ecc_done;
  logic [7:0] ecc_lo, ecc_mid, ecc_hi;

  always #4 clk = ~clk;

  nand_hamming_gen i_nand_hamming_gen (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sos(in_sos),
    .in_data(in_data), .ecc_done(ecc_done), .ecc_lo(ecc_lo),
    .ecc_mid(ecc_mid), .ecc_hi(ecc_hi));

  int checks = 0, failures = 0;
  string cur_req = "R1";
  byte unsigned sect[$];
  logic exp_done = 1'b0;
  logic [23:0] exp_code = 24'hFFFFFF;

  function automatic logic [23:0] model_code();
    logic [8:0] pt, pp;
    logic [2:0] ct, cp;
    logic [7:0] hi, mid, lo;
    pt = '0; pp = '0; ct = '0; cp = '0;
    for (int i = 0; i < sect.size(); i++)
      for (int b = 0; b < 8; b++)
        if (sect[i][b]) begin
          for (int k = 0; k < 9; k++)
            if (i[k]) pt[k] = ~pt[k]; else pp[k] = ~pp[k];
          for (int k = 0; k < 3; k++)
            if (b[k]) ct[k] = ~ct[k]; else cp[k] = ~cp[k];
        end
    hi = {ct[2], cp[2], ct[1], cp[1], ct[0], cp[0], pt[8], pp[8]};
    for (int k = 0; k < 4; k++) begin
      mid[2*k+1] = pt[k+4]; mid[2*k] = pp[k+4];
      lo[2*k+1]  = pt[k];   lo[2*k]  = pp[k];
    end
    return ~{hi, mid, lo};
  endfunction

  task automatic compare();
    checks++;
    if (ecc_done !== exp_done) begin
      failures++;
      $display("FAIL %s done actual=%0b expected=%0b", cur_req, ecc_done, exp_done);
    end
    checks++;
    if ({ecc_hi, ecc_mid, ecc_lo} !== exp_code) begin
      failures++;
      $display("FAIL %s code actual=%06h expected=%06h", cur_req,
               {ecc_hi, ecc_mid, ecc_lo}, exp_code);
    end
  endtask

  task automatic step(input logic v, input logic s, input logic [7:0] d);
    in_valid = v; in_sos = s; in_data = d;
    exp_done = 1'b0;
    if (v) begin
      if (s) sect.delete();
      sect.push_back(d);
      if (sect.size() == 512) begin
        exp_code = model_code();
        exp_done = 1'b1;
        sect.delete();
      end
    end
    @(posedge clk);
    @(negedge clk);
    compare();
  endtask

  task automatic single_bit(input int pos, input int bitn);
    for (int i = 0; i < 512; i++)
      step(1'b1, i == 0, (i == pos) ? 8'(1 << bitn) : 8'h00);
  endtask

  initial begin
    #(8 * 200000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    cur_req = "R1";
    compare();

    cur_req = "R9";
    for (int i = 0; i < 512; i++) step(1'b1, i == 0, 8'hFF);
    cur_req = "R11";
    for (int i = 0; i < 512; i++) step(1'b1, 1'b0, 8'h00);
    checks++;
    if (exp_code !== 24'hFFFFFF) begin
      failures++;
      $display("FAIL R9 model actual=%06h expected=ffffff", exp_code);
    end

    cur_req = "R8";
    single_bit(0, 0);
    checks++;
    if ({ecc_hi, ecc_mid, ecc_lo} !== 24'hAAAAAA) begin
      failures++;
      $display("FAIL R8 code actual=%06h expected=aaaaaa", {ecc_hi, ecc_mid, ecc_lo});
    end
    cur_req = "R6";
    single_bit(511, 7);
    cur_req = "R7";
    single_bit(9'h155, 5);
    cur_req = "R4";
    single_bit(9'h0AA, 2);
    cur_req = "R5";
    single_bit(9'h0F0, 3);

    cur_req = "R2";
    for (int n = 0; n < 512; ) begin
      if ($urandom_range(0, 3) == 0) step(1'b0, 1'($urandom), 8'($urandom));
      else begin step(1'b1, n == 0, 8'($urandom)); n++; end
    end

    cur_req = "R3";
    for (int i = 0; i < 100; i++) step(1'b1, i == 0, 8'($urandom));
    for (int i = 0; i < 512; i++) step(1'b1, i == 0, 8'($urandom));

    cur_req = "R10";
    for (int i = 0; i < 20; i++) step(1'b0, 1'b0, 8'($urandom));
    for (int i = 0; i < 512; i++) step(1'b1, i == 0, 8'($urandom));
    for (int i = 0; i < 512; i++) step(1'b1, i == 0, 8'($urandom));
    for (int i = 0; i < 5; i++) step(1'b0, 1'b0, 8'h00);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule